// File: doc/BRIEF.md
# Serial Avionics Word Channel Controller (one transmitter, two receivers)

The block moves 32-bit avionics data words over return-to-zero differential line pairs. One transmitter takes a 31-bit payload through a valid/ready handshake. It appends a parity bit of the selected sense and shifts the 32 bits out least significant first. A 1 is a half-period high on line A, a 0 is a half-period high on line B, and both lines are low (null) for the second half of every bit. At least four null bit-times follow each word. Two receivers oversample their own line pairs at 16 ticks per bit. They rebuild each word, check it for odd parity, and deliver it with a one-cycle valid strobe. Each receiver can drop words whose two source/destination bits do not match a per-receiver mask.

A single 16-bit control word configures the whole block. It selects loop-back, the two filters, the transmit parity sense and the bit rate of each direction (fast, or eight times slower). In loop-back the transmitter feeds both receivers internally. Receiver 0 sees the pair as driven. Receiver 1 sees A and B swapped, so every bit arrives complemented. The external transmit pins are held null and the external receive pins are ignored.

The transmitter runs the state machine TX_IDLE → TX_BIT → TX_GAP → TX_IDLE. TX_IDLE goes to TX_BIT when a word is accepted. TX_BIT goes to TX_GAP after the last tick of bit 32. TX_GAP goes to TX_IDLE after 64 null ticks. Each receiver runs RX_IDLE → RX_PULSE on the first tick with exactly one line high. RX_PULSE goes to RX_NULL when both lines are low. RX_NULL goes back to RX_PULSE on the next pulse. RX_NULL goes to RX_IDLE after 24 consecutive null ticks, and that marks the end of the word.

Top module: `a429_ctl`

## Requirements
- R1: Control word bits 0 to 4 and bit 15 are ignored on write and read back as 0. The register reads 0x0020 after reset, and a write is visible on `cfg_rdata` one cycle later.
- R2: A transmitted payload `tx_data[k]` arrives as received word bit k (bit 0 first on the line). When the external line pair is looped back to a receiver, that receiver outputs the payload unchanged. The two transmit lines are never high together.
- R3: Received word bit 31 is the parity bit. With control bit 12 = 0 the 32-bit word has an odd number of ones, and with bit 12 = 1 it has an even number.
- R4: A receiver raises `rx_par_err` together with `rx_valid` when the delivered 32-bit word has an even number of ones. Otherwise `rx_par_err` is 0.
- R5: With control bit 6 (receiver 0) or bit 9 (receiver 1) set, a receiver delivers a word only if word bits [9:8] equal the mask {bit 8, bit 7} (receiver 0) or {bit 11, bit 10} (receiver 1). Otherwise the word produces no valid. With the enable bit clear, every complete word is delivered.
- R6: With control bit 5 = 0 (loop-back), receiver 0 delivers the transmitted word and receiver 1 delivers its bitwise complement.
- R7: In loop-back, `tx_line_a` and `tx_line_b` stay low, and activity on `rx_line_a`/`rx_line_b` has no effect on the received words.
- R8: Control bit 13 (transmit) and bit 14 (receive) select the rate: 0 gives 16·DIV_FAST clocks per bit, 1 gives 128·DIV_FAST. The first half-bit pulse lasts 8·DIV_FAST or 64·DIV_FAST clocks.
- R9: When a word ends (24 null ticks) with a bit count other than 32, the receiver pulses `rx_frm_err` for one cycle and raises no `rx_valid`.
- R10: `tx_ready` is high when idle. It drops in the cycle after a word is accepted and stays low for exactly 576 ticks (32 bits plus 4 null bit-times), which is 576·clocks-per-tick.

Ports are listed below. Index 0 of each receiver array is receiver 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Current control word (reserved bits 0) |
| tx_data | input | 31 | Transmit payload, bit 0 sent first |
| tx_valid | input | 1 | Transmit payload valid |
| tx_ready | output | 1 | Transmitter idle, accepts a payload |
| tx_line_a | output | 1 | Transmit line A (ones) |
| tx_line_b | output | 1 | Transmit line B (zeros) |
| rx_line_a | input | 2 | Receive line A per receiver |
| rx_line_b | input | 2 | Receive line B per receiver |
| rx_data | output | 2x32 | Received word per receiver |
| rx_valid | output | 2 | One-cycle received-word strobe |
| rx_par_err | output | 2 | Parity error, qualified by rx_valid |
| rx_frm_err | output | 2 | One-cycle wrong-length strobe |

## Verification
The control word read-back is due one cycle after the write strobe, and the bench samples it at the next falling edge. `tx_ready` falls one cycle after acceptance and returns exactly 576 ticks later. The first line pulse lasts exactly 8 ticks. Both are counted in falling-edge samples starting right after the accepting edge, so each is compared against an exact cycle count. Received words, parity flags and framing strobes are due 24 null ticks after the last pulse plus two synchroniser cycles, which is always inside the transmitter's trailing gap. A monitor therefore tallies every strobe into per-receiver counters, and the bench compares those counters once the transmitter has returned to idle and a further fixed margin has passed.

// File: rtl/a429_pkg.sv
package a429_pkg;
    localparam int WORD_W     = 32;
    localparam int NRX        = 2;
    localparam int OS_RATE    = 16;
    localparam int HALF_TICKS = OS_RATE / 2;
    localparam int GAP_BITS   = 4;
    localparam int GAP_TICKS  = GAP_BITS * OS_RATE;
    localparam int END_TICKS  = (OS_RATE * 3) / 2;
    localparam int SLOW_MULT  = 8;

    localparam int CB_LOOP_N  = 5;
    localparam int CB_FLT0    = 6;
    localparam int CB_STRIDE  = 3;
    localparam int CB_TXPAR   = 12;
    localparam int CB_TXRATE  = 13;
    localparam int CB_RXRATE  = 14;

    localparam logic [15:0] CFG_MASK  = 16'h7FE0;
    localparam logic [15:0] CFG_RESET = 16'h0020;

    typedef enum logic [1:0] {TX_IDLE, TX_BIT, TX_GAP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_PULSE, RX_NULL} rx_state_t;
endpackage

// File: rtl/a429_tick.sv
module a429_tick #(
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick
);
    import a429_pkg::*;
    localparam int DIV_SLOW = DIV_FAST * SLOW_MULT;
    localparam int CW       = $clog2(DIV_SLOW + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        lim  = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
        tick = run && (cnt >= lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (!run)   cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/a429_tx.sv
module a429_tx (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        even_par,
    input  logic [a429_pkg::WORD_W-2:0] data,
    input  logic                        valid,
    output logic                        ready,
    output logic                        run,
    output logic                        line_a,
    output logic                        line_b
);
    import a429_pkg::*;
    localparam int SUB_W = $clog2(OS_RATE);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int GAP_W = $clog2(GAP_TICKS);

    tx_state_t         st, st_n;
    logic [WORD_W-1:0] sh, sh_n;
    logic [SUB_W-1:0]  sub, sub_n;
    logic [BIT_W-1:0]  bcnt, bcnt_n;
    logic [GAP_W-1:0]  gcnt, gcnt_n;
    logic              par;

    always_comb begin
        par    = even_par ? (^data) : ~(^data);
        st_n   = st;
        sh_n   = sh;
        sub_n  = sub;
        bcnt_n = bcnt;
        gcnt_n = gcnt;
        unique case (st)
            TX_IDLE: begin
                if (valid) begin
                    st_n   = TX_BIT;
                    sh_n   = {par, data};
                    sub_n  = '0;
                    bcnt_n = '0;
                end
            end
            TX_BIT: begin
                if (tick) begin
                    sub_n = sub + 1'b1;
                    if (sub == SUB_W'(OS_RATE - 1)) begin
                        sh_n   = sh >> 1;
                        bcnt_n = bcnt + 1'b1;
                        if (bcnt == BIT_W'(WORD_W - 1)) begin
                            st_n   = TX_GAP;
                            gcnt_n = '0;
                        end
                    end
                end
            end
            TX_GAP: begin
                if (tick) begin
                    gcnt_n = gcnt + 1'b1;
                    if (gcnt == GAP_W'(GAP_TICKS - 1)) st_n = TX_IDLE;
                end
            end
            default: st_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= TX_IDLE;
            sh   <= '0;
            sub  <= '0;
            bcnt <= '0;
            gcnt <= '0;
        end else begin
            st   <= st_n;
            sh   <= sh_n;
            sub  <= sub_n;
            bcnt <= bcnt_n;
            gcnt <= gcnt_n;
        end
    end

    always_comb begin
        ready  = (st == TX_IDLE);
        run    = (st != TX_IDLE);
        line_a = (st == TX_BIT) && (sub < SUB_W'(HALF_TICKS)) &&  sh[0];
        line_b = (st == TX_BIT) && (sub < SUB_W'(HALF_TICKS)) && !sh[0];
    end
endmodule

// File: rtl/a429_rx.sv
module a429_rx (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        line_a,
    input  logic                        line_b,
    input  logic                        flt_en,
    input  logic [1:0]                  flt_mask,
    output logic [a429_pkg::WORD_W-1:0] data,
    output logic                        valid,
    output logic                        par_err,
    output logic                        frm_err
);
    import a429_pkg::*;
    localparam int BC_W  = $clog2(WORD_W + 2);
    localparam int END_W = $clog2(END_TICKS);

    logic [1:0]        a_sync, b_sync;
    logic              a, b;
    rx_state_t         st, st_n;
    logic [WORD_W-1:0] sh, sh_n;
    logic [BC_W-1:0]   bcnt, bcnt_n;
    logic [END_W-1:0]  ncnt, ncnt_n;
    logic              fin, full, pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sync <= '0;
            b_sync <= '0;
        end else begin
            a_sync <= {a_sync[0], line_a};
            b_sync <= {b_sync[0], line_b};
        end
    end

    always_comb begin
        a      = a_sync[1];
        b      = b_sync[1];
        st_n   = st;
        sh_n   = sh;
        bcnt_n = bcnt;
        ncnt_n = ncnt;
        fin    = 1'b0;
        unique case (st)
            RX_IDLE: begin
                if (tick && (a ^ b)) begin
                    st_n   = RX_PULSE;
                    sh_n   = {a, sh[WORD_W-1:1]};
                    bcnt_n = BC_W'(1);
                end
            end
            RX_PULSE: begin
                if (tick && !a && !b) begin
                    st_n   = RX_NULL;
                    ncnt_n = '0;
                end
            end
            RX_NULL: begin
                if (tick) begin
                    if (a ^ b) begin
                        st_n   = RX_PULSE;
                        sh_n   = {a, sh[WORD_W-1:1]};
                        bcnt_n = (bcnt == BC_W'(WORD_W + 1)) ? bcnt : bcnt + 1'b1;
                    end else if (!a && !b) begin
                        if (ncnt == END_W'(END_TICKS - 1)) begin
                            st_n = RX_IDLE;
                            fin  = 1'b1;
                        end else begin
                            ncnt_n = ncnt + 1'b1;
                        end
                    end
                end
            end
            default: st_n = RX_IDLE;
        endcase
        full = (bcnt == BC_W'(WORD_W));
        pass = !flt_en || (sh[9:8] == flt_mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            sh   <= '0;
            bcnt <= '0;
            ncnt <= '0;
        end else begin
            st   <= st_n;
            sh   <= sh_n;
            bcnt <= bcnt_n;
            ncnt <= ncnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data    <= '0;
            valid   <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            valid   <= fin && full && pass;
            par_err <= fin && full && pass && ~(^sh);
            frm_err <= fin && !full;
            if (fin && full && pass) data <= sh;
        end
    end
endmodule

// File: rtl/a429_ctl.sv
module a429_ctl #(
    parameter int DIV_FAST = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cfg_we,
    input  logic [15:0]                               cfg_wdata,
    output logic [15:0]                               cfg_rdata,
    input  logic [a429_pkg::WORD_W-2:0]               tx_data,
    input  logic                                      tx_valid,
    output logic                                      tx_ready,
    output logic                                      tx_line_a,
    output logic                                      tx_line_b,
    input  logic [a429_pkg::NRX-1:0]                  rx_line_a,
    input  logic [a429_pkg::NRX-1:0]                  rx_line_b,
    output logic [a429_pkg::NRX-1:0][a429_pkg::WORD_W-1:0] rx_data,
    output logic [a429_pkg::NRX-1:0]                  rx_valid,
    output logic [a429_pkg::NRX-1:0]                  rx_par_err,
    output logic [a429_pkg::NRX-1:0]                  rx_frm_err
);
    import a429_pkg::*;

    logic [15:0] cfg;
    logic        loop_en;
    logic        tx_tick, tx_run, rx_tick;
    logic        int_a, int_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg <= CFG_RESET;
        else if (cfg_we) cfg <= cfg_wdata & CFG_MASK;
    end

    always_comb begin
        cfg_rdata = cfg;
        loop_en   = !cfg[CB_LOOP_N];
        tx_line_a = int_a && !loop_en;
        tx_line_b = int_b && !loop_en;
    end

    a429_tick #(.DIV_FAST(DIV_FAST)) u_tx_tick (
        .clk(clk), .rst_n(rst_n), .run(tx_run),
        .slow(cfg[CB_TXRATE]), .tick(tx_tick)
    );

    a429_tick #(.DIV_FAST(DIV_FAST)) u_rx_tick (
        .clk(clk), .rst_n(rst_n), .run(1'b1),
        .slow(cfg[CB_RXRATE]), .tick(rx_tick)
    );

    a429_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick),
        .even_par(cfg[CB_TXPAR]), .data(tx_data), .valid(tx_valid),
        .ready(tx_ready), .run(tx_run), .line_a(int_a), .line_b(int_b)
    );

    for (genvar i = 0; i < NRX; i++) begin : g_rx
        logic sel_a, sel_b;
        if (i == 0) begin : g_true
            always_comb begin
                sel_a = loop_en ? int_a : rx_line_a[i];
                sel_b = loop_en ? int_b : rx_line_b[i];
            end
        end else begin : g_swap
            always_comb begin
                sel_a = loop_en ? int_b : rx_line_a[i];
                sel_b = loop_en ? int_a : rx_line_b[i];
            end
        end

        a429_rx u_rx (
            .clk(clk), .rst_n(rst_n), .tick(rx_tick),
            .line_a(sel_a), .line_b(sel_b),
            .flt_en(cfg[CB_FLT0 + CB_STRIDE*i]),
            .flt_mask(cfg[CB_FLT0 + CB_STRIDE*i + 1 +: 2]),
            .data(rx_data[i]), .valid(rx_valid[i]),
            .par_err(rx_par_err[i]), .frm_err(rx_frm_err[i])
        );
    end
endmodule

// File: rtl/a429_ctl_chk.sv
module a429_ctl_chk (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      cfg_we,
    input logic [15:0]                               cfg_wdata,
    input logic [15:0]                               cfg_rdata,
    input logic                                      tx_valid,
    input logic                                      tx_ready,
    input logic                                      tx_line_a,
    input logic                                      tx_line_b,
    input logic [a429_pkg::NRX-1:0][a429_pkg::WORD_W-1:0] rx_data,
    input logic [a429_pkg::NRX-1:0]                  rx_valid,
    input logic [a429_pkg::NRX-1:0]                  rx_par_err,
    input logic [a429_pkg::NRX-1:0]                  rx_frm_err
);
    import a429_pkg::*;

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~CFG_MASK) == 16'h0000);

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata == ($past(cfg_wdata) & CFG_MASK));

    assert_lines_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_line_a && tx_line_b));

    assert_loop_pins_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[CB_LOOP_N] |-> (!tx_line_a && !tx_line_b));

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    for (genvar i = 0; i < NRX; i++) begin : g_chk
        assert_perr_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rx_par_err[i] |-> rx_valid[i]);

        assert_frm_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(rx_valid[i] && rx_frm_err[i]));

        assert_sdi_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[i] && cfg_rdata[CB_FLT0 + CB_STRIDE*i]) |->
            (rx_data[i][9:8] == cfg_rdata[CB_FLT0 + CB_STRIDE*i + 1 +: 2]));
    end
endmodule

bind a429_ctl a429_ctl_chk u_chk (.*);

// File: tb/a429_ctl_tb.sv
`timescale 1ns/1ps
module a429_ctl_tb;
    import a429_pkg::*;
    localparam int DIVF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [30:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, tx_line_a, tx_line_b;
    logic [1:0]  rx_line_a, rx_line_b;
    logic [1:0][31:0] rx_data;
    logic [1:0]  rx_valid, rx_par_err, rx_frm_err;

    logic        loop_mode = 1'b0;
    logic [1:0]  drv_a = '0, drv_b = '0;
    logic        clr = 1'b0;

    int          total = 0, fails = 0;
    int          vcnt [2];
    int          fcnt [2];
    logic [31:0] vdat [2];
    logic        vperr [2];
    int          linehits;

    always #2 clk = ~clk;

    assign rx_line_a = loop_mode ? {2{tx_line_a}} : drv_a;
    assign rx_line_b = loop_mode ? {2{tx_line_b}} : drv_b;

    a429_ctl #(.DIV_FAST(DIVF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_line_a(tx_line_a), .tx_line_b(tx_line_b),
        .rx_line_a(rx_line_a), .rx_line_b(rx_line_b), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 2; i++) begin
                vcnt[i] <= 0; fcnt[i] <= 0; vdat[i] <= '0; vperr[i] <= 1'b0;
            end
            linehits <= 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (rx_valid[i]) begin
                    vcnt[i]  <= vcnt[i] + 1;
                    vdat[i]  <= rx_data[i];
                    vperr[i] <= rx_par_err[i];
                end
                if (rx_frm_err[i]) fcnt[i] <= fcnt[i] + 1;
            end
            if (tx_line_a || tx_line_b) linehits <= linehits + 1;
        end
    end

    // {control word, payload}
    localparam logic [47:0] VEC [9] = '{
        {16'h0020, 32'h12345678},
        {16'h1020, 32'h0F0F1234},
        {16'h00E0, 32'h000001AB},
        {16'h00E0, 32'h000002AB},
        {16'h0E20, 32'h00000355},
        {16'h0000, 32'h25A500FF},
        {16'h0200, 32'h00000300},
        {16'h6020, 32'h7654ABCD},
        {16'h1000, 32'h00000042}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic send(input logic [30:0] d, output int busy, output int pw);
        bit seen, done;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data = d; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        busy = 0; pw = 0; seen = 0; done = 0;
        while (!tx_ready) begin
            busy++;
            if (!done) begin
                if (tx_line_a || tx_line_b) begin pw++; seen = 1; end
                else done = 1;
            end
            @(negedge clk);
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic drive_bits(input logic [33:0] w, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drv_a = {2{w[k]}}; drv_b = {2{~w[k]}};
            repeat (8 * DIVF) @(negedge clk);
            drv_a = '0; drv_b = '0;
            repeat (8 * DIVF - 1) @(negedge clk);
        end
        repeat (40 * DIVF) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] cv;
        logic [30:0] d;
        logic [31:0] w, wi;
        logic        p, acc, fen, wrap;
        logic [1:0]  m;
        int          busy, pw, div;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 16'h0020, "R1", "reset control word", 32'(cfg_rdata), 32'h20);
        chk(tx_ready == 1'b1, "R10", "ready after reset", 32'(tx_ready), 1);
        chk({tx_line_a, tx_line_b, rx_valid} == '0, "R2", "outputs null after reset",
            32'({tx_line_a, tx_line_b, rx_valid}), 0);

        loop_mode = 1'b1;
        for (int k = 0; k < 9; k++) begin
            cv = VEC[k][47:32];
            d  = VEC[k][30:0];
            write_cfg(cv | 16'h801F);
            chk(cfg_rdata == cv, "R1", "readback masks reserved bits", 32'(cfg_rdata), 32'(cv));
            clear_mon();
            send(d, busy, pw);
            wrap = !cv[5];
            div  = cv[13] ? DIVF * 8 : DIVF;
            p    = cv[12] ? ^d : ~(^d);
            w    = {p, d};
            chk(busy == 576 * div, cv[13] ? "R8" : "R10", "busy cycles", 32'(busy), 32'(576 * div));
            if (wrap) chk(linehits == 0, "R7", "pins null in loop-back", 32'(linehits), 0);
            else      chk(pw == 8 * div, "R8", "first pulse width", 32'(pw), 32'(8 * div));
            for (int i = 0; i < 2; i++) begin
                wi  = (wrap && i == 1) ? ~w : w;
                fen = cv[6 + 3 * i];
                m   = cv[7 + 3 * i +: 2];
                acc = !fen || (wi[9:8] == m);
                chk(vcnt[i] == int'(acc), fen ? "R5" : "R2", "word count", 32'(vcnt[i]), 32'(acc));
                if (acc) begin
                    chk(vdat[i] == wi, wrap ? "R6" : "R2", "received word", vdat[i], wi);
                    chk(vperr[i] == ~(^wi), "R4", "parity flag", 32'(vperr[i]), 32'(~(^wi)));
                    if (i == 0)
                        chk(vdat[0][31] == p, "R3", "parity bit sense", 32'(vdat[0][31]), 32'(p));
                end
                chk(fcnt[i] == 0, "R9", "no framing error on good word", 32'(fcnt[i]), 0);
            end
        end

        // externally driven words, external path, fast rates
        loop_mode = 1'b0;
        write_cfg(16'h0020);
        clear_mon();
        drive_bits({2'b00, 32'h00000103}, 32);
        chk(vcnt[0] == 1 && vdat[0] == 32'h00000103, "R2", "driven word rx0", vdat[0], 32'h103);
        chk(vperr[1] == 1'b0, "R4", "odd word no parity error", 32'(vperr[1]), 0);
        clear_mon();
        drive_bits({2'b00, 32'h00000003}, 32);
        chk(vcnt[1] == 1 && vperr[1] == 1'b1, "R4", "even word flagged", 32'(vperr[1]), 1);
        clear_mon();
        drive_bits({2'b00, 32'h0000025A}, 10);
        chk(fcnt[0] == 1 && fcnt[1] == 1, "R9", "short word framing", 32'(fcnt[0]), 1);
        chk(vcnt[0] == 0 && vcnt[1] == 0, "R9", "short word no valid", 32'(vcnt[0]), 0);
        clear_mon();
        drive_bits({2'b01, 32'h00000103}, 33);
        chk(fcnt[0] == 1 && vcnt[0] == 0, "R9", "long word framing", 32'(fcnt[0]), 1);

        // loop-back with junk on the external receive pins
        write_cfg(16'h0000);
        @(negedge clk);
        drv_a = 2'b01; drv_b = 2'b10;
        clear_mon();
        send(31'h0ABC0123, busy, pw);
        w = {~(^31'h0ABC0123), 31'h0ABC0123};
        chk(vcnt[0] == 1 && vdat[0] == w, "R7", "rx0 ignores pins", vdat[0], w);
        chk(vcnt[1] == 1 && vdat[1] == ~w, "R7", "rx1 ignores pins", vdat[1], ~w);
        chk(linehits == 0, "R7", "pins null", 32'(linehits), 0);
        drv_a = '0; drv_b = '0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule